// File: doc/BRIEF.md
# Rotating Register Rename Unit

This unit turns architectural register numbers into physical register indices for three register classes: general, floating-point and predicate. Each class has a fixed low region that maps straight through and a rotating upper region. Inside the rotating region the physical index is the virtual index plus a per-class rotation base, wrapped around the region size. Software-pipelined loops use this so that a value written to the first rotating register moves up one register number on each loop iteration without any data being copied.

A single rotate strobe steps all three bases down by one, each modulo its own region size. A clear strobe returns all bases to zero. The size of the general rotating window is programmable in groups of eight registers. The floating-point and predicate windows have fixed sizes. Whoever programs the general window size must keep it within the input-plus-local part of the current stacked frame; the unit does not know the frame. Each read and write port maps combinationally from the current bases. The unit also flags the hardwired constant registers, gives their constant value, and suppresses writes to them.

Top module: `rot_rename_unit`

## Requirements
- R1: Class code 0 selects general, 1 floating-point, 2 predicate, and code 3 is treated as general. General and floating-point indices below 32 and predicate indices below 16 map to the same physical index.
- R2: A floating-point index v in 32..127 maps to 32 + ((v − 32 + base) mod 96). A predicate index v in 16..63 maps to 16 + ((v − 16 + base) mod 48). A general index v with 32 ≤ v < 32 + S maps to 32 + ((v − 32 + base) mod S), where S is the general window size; general indices at or above 32 + S map straight through.
- R3: A rotate strobe lowers every base by one modulo its region size, taking effect from the following cycle. A physical register reached through index 32 (predicate 16) is reached through index 33 (predicate 17) after one rotation.
- R4: A clear strobe sets all three bases to zero in one cycle and wins over a rotate strobe in the same cycle.
- R5: The 4-bit window-size input counts groups of 8 general registers (S = 8 × groups). Values above 12 act as 12 (S = 96). With S = 0 every general index maps straight through, and a rotation leaves the general base at zero.
- R6: Each read port flags a hardwired register and its value: general 0 gives 0, floating-point 0 gives 0, floating-point 1 gives 1, predicate 0 gives 1. No other register is flagged.
- R7: A write port's write-go output equals its write enable, except that it is 0 when the target is a hardwired register from R6.
- R8: For the predicate class, bit 6 of the index is ignored, and the physical index has bit 6 clear.
- R9: After reset all bases are zero, so every index maps straight through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rotate | input | 1 | Step all rotation bases down by one |
| base_clr | input | 1 | Set all rotation bases to zero |
| gr_grp | input | 4 | General rotating window size in groups of 8 |
| rd_cls | input | RD_PORTS×2 | Class code per read port |
| rd_idx | input | RD_PORTS×7 | Architectural index per read port |
| wr_en | input | WR_PORTS | Write enable per write port |
| wr_cls | input | WR_PORTS×2 | Class code per write port |
| wr_idx | input | WR_PORTS×7 | Architectural index per write port |
| rd_phys | output | RD_PORTS×7 | Physical index per read port |
| rd_hard | output | RD_PORTS | Read target is a hardwired register |
| rd_hard_val | output | RD_PORTS | Constant value of the hardwired register |
| wr_phys | output | WR_PORTS×7 | Physical index per write port |
| wr_go | output | WR_PORTS | Write enable after hardwired-register suppression |

## Verification
Random port traffic over all class codes and all 128 index values, mixed with random rotate and clear strobes and window-size changes, is compared every cycle against a wrap-around model. This separates errors in the fixed/rotating boundary from errors in base stepping. Directed cases follow one physical register from index 32 to 33, and from predicate 16 to 17, across a rotation, which shows the direction of rotation. Further directed cases cover clear against rotate in the same cycle, window sizes of zero and above the limit, and predicate indices with bit 6 set. Writes to each hardwired register show that suppression applies to those registers only.

// File: rtl/rrn_pkg.sv
package rrn_pkg;

  localparam int IDX_W      = 7;
  localparam int ROT_LO     = 32;
  localparam int PR_LO      = 16;
  localparam int FR_ROT_N   = 96;
  localparam int PR_ROT_N   = 48;
  localparam int GR_GRP_MAX = 12;
  localparam int WRAP_STEPS = 24;

  typedef enum logic [1:0] {
    CLS_GR = 2'd0,
    CLS_FR = 2'd1,
    CLS_PR = 2'd2,
    CLS_XX = 2'd3
  } reg_cls_e;

  // reduce val modulo n by repeated subtraction (val < 24*n for all uses)
  function automatic logic [7:0] wrap_mod(input logic [7:0] val, input logic [6:0] n);
    logic [7:0] r;
    r = val;
    for (int i = 0; i < WRAP_STEPS; i++)
      if (n != 7'd0 && r >= {1'b0, n}) r = r - {1'b0, n};
    return r;
  endfunction

  // general window size in registers from the group count, clamped
  function automatic logic [6:0] gr_span_of(input logic [3:0] grp);
    logic [3:0] g;
    g = (grp > 4'(GR_GRP_MAX)) ? 4'(GR_GRP_MAX) : grp;
    return {g, 3'b000};
  endfunction

  // modular offset inside window [lo, lo+n), passthrough outside
  function automatic logic [6:0] rot_map(input logic [6:0] v, input logic [6:0] lo,
                                         input logic [6:0] n, input logic [6:0] rrb);
    logic [7:0] lim;
    logic [7:0] off;
    lim = {1'b0, lo} + {1'b0, n};
    if (n == 7'd0 || v < lo || {1'b0, v} >= lim) return v;
    off = wrap_mod({1'b0, 7'(v - lo)} + {1'b0, rrb}, n);
    return 7'(lo + off[6:0]);
  endfunction

  // one step down, modulo n
  function automatic logic [6:0] rrb_dec(input logic [6:0] rrb, input logic [6:0] n);
    logic [7:0] r;
    if (n == 7'd0) return 7'd0;
    r = wrap_mod({1'b0, rrb}, n);
    return (r == 8'd0) ? 7'(n - 7'd1) : 7'(r[6:0] - 7'd1);
  endfunction

endpackage

// File: rtl/rrn_base_ctl.sv
module rrn_base_ctl
  import rrn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rotate,
  input  logic             base_clr,
  input  logic [IDX_W-1:0] gr_span,
  output logic [IDX_W-1:0] gr_rrb,
  output logic [IDX_W-1:0] fr_rrb,
  output logic [IDX_W-1:0] pr_rrb
);

  logic step_evt;
  logic clr_evt;
  assign clr_evt  = base_clr;
  assign step_evt = rotate & ~base_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gr_rrb <= '0;
      fr_rrb <= '0;
      pr_rrb <= '0;
    end else if (clr_evt) begin
      gr_rrb <= '0;
      fr_rrb <= '0;
      pr_rrb <= '0;
    end else if (step_evt) begin
      gr_rrb <= rrb_dec(gr_rrb, gr_span);
      fr_rrb <= rrb_dec(fr_rrb, 7'(FR_ROT_N));
      pr_rrb <= rrb_dec(pr_rrb, 7'(PR_ROT_N));
    end
  end

  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (gr_rrb == '0 && fr_rrb == '0 && pr_rrb == '0));

  // R3
  pr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (pr_rrb != $past(pr_rrb)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rotate && !base_clr) |=> ($stable(fr_rrb) && $stable(pr_rrb) && $stable(gr_rrb)));

  // R5
  gr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && gr_span == '0) |=> (gr_rrb == '0));

  // R2
  base_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_rrb < 7'(FR_ROT_N)) && (pr_rrb < 7'(PR_ROT_N)));

endmodule

// File: rtl/rrn_port_map.sv
module rrn_port_map
  import rrn_pkg::*;
(
  input  logic [1:0]       cls,
  input  logic [IDX_W-1:0] vidx,
  input  logic [IDX_W-1:0] gr_span,
  input  logic [IDX_W-1:0] gr_rrb,
  input  logic [IDX_W-1:0] fr_rrb,
  input  logic [IDX_W-1:0] pr_rrb,
  output logic [IDX_W-1:0] phys,
  output logic             hard,
  output logic             hard_val
);

  logic [IDX_W-1:0] v_pr;
  assign v_pr = {1'b0, vidx[IDX_W-2:0]};

  always_comb begin
    case (reg_cls_e'(cls))
      CLS_PR: begin
        phys     = rot_map(v_pr, 7'(PR_LO), 7'(PR_ROT_N), pr_rrb);
        hard     = (v_pr == '0);
        hard_val = 1'b1;
      end
      CLS_FR: begin
        phys     = rot_map(vidx, 7'(ROT_LO), 7'(FR_ROT_N), fr_rrb);
        hard     = (vidx < 7'd2);
        hard_val = vidx[0];
      end
      default: begin
        phys     = rot_map(vidx, 7'(ROT_LO), gr_span, gr_rrb);
        hard     = (vidx == '0);
        hard_val = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/rot_rename_unit.sv
module rot_rename_unit
  import rrn_pkg::*;
#(
  parameter int RD_PORTS = 3,
  parameter int WR_PORTS = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rotate,
  input  logic                               base_clr,
  input  logic [3:0]                         gr_grp,
  input  logic [RD_PORTS-1:0][1:0]           rd_cls,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]     rd_idx,
  input  logic [WR_PORTS-1:0]                wr_en,
  input  logic [WR_PORTS-1:0][1:0]           wr_cls,
  input  logic [WR_PORTS-1:0][IDX_W-1:0]     wr_idx,
  output logic [RD_PORTS-1:0][IDX_W-1:0]     rd_phys,
  output logic [RD_PORTS-1:0]                rd_hard,
  output logic [RD_PORTS-1:0]                rd_hard_val,
  output logic [WR_PORTS-1:0][IDX_W-1:0]     wr_phys,
  output logic [WR_PORTS-1:0]                wr_go
);

  logic [IDX_W-1:0] gr_span;
  logic [IDX_W-1:0] gr_rrb, fr_rrb, pr_rrb;

  assign gr_span = gr_span_of(gr_grp);

  rrn_base_ctl u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .rotate   (rotate),
    .base_clr (base_clr),
    .gr_span  (gr_span),
    .gr_rrb   (gr_rrb),
    .fr_rrb   (fr_rrb),
    .pr_rrb   (pr_rrb)
  );

  for (genvar i = 0; i < RD_PORTS; i++) begin : g_rd
    rrn_port_map u_map (
      .cls      (rd_cls[i]),
      .vidx     (rd_idx[i]),
      .gr_span  (gr_span),
      .gr_rrb   (gr_rrb),
      .fr_rrb   (fr_rrb),
      .pr_rrb   (pr_rrb),
      .phys     (rd_phys[i]),
      .hard     (rd_hard[i]),
      .hard_val (rd_hard_val[i])
    );

    // R1
    low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cls[i] != 2'(CLS_PR) && rd_idx[i] < 7'(ROT_LO)) |-> (rd_phys[i] == rd_idx[i]));

    // R8
    pr_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cls[i] == 2'(CLS_PR)) |-> (rd_phys[i][IDX_W-1] == 1'b0));

    // R6
    p0_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cls[i] == 2'(CLS_PR) && rd_idx[i][IDX_W-2:0] == '0) |-> (rd_hard[i] && rd_hard_val[i]));
  end

  for (genvar j = 0; j < WR_PORTS; j++) begin : g_wr
    logic w_hard;
    logic w_val;

    rrn_port_map u_map (
      .cls      (wr_cls[j]),
      .vidx     (wr_idx[j]),
      .gr_span  (gr_span),
      .gr_rrb   (gr_rrb),
      .fr_rrb   (fr_rrb),
      .pr_rrb   (pr_rrb),
      .phys     (wr_phys[j]),
      .hard     (w_hard),
      .hard_val (w_val)
    );

    assign wr_go[j] = wr_en[j] & ~w_hard;

    // R7
    wr_go_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go[j] |-> wr_en[j]);

    // R7
    wr_r0_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cls[j] == 2'(CLS_GR) && wr_idx[j] == '0) |-> !wr_go[j]);
  end

endmodule

// File: tb/rot_rename_unit_test.sv
`timescale 1ns/1ps
module rot_rename_unit_test;

  localparam int NRD = 3;
  localparam int NWR = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rotate = 1'b0;
  logic base_clr = 1'b0;
  logic [3:0] gr_grp = 4'd0;
  logic [NRD-1:0][1:0] rd_cls = '0;
  logic [NRD-1:0][6:0] rd_idx = '0;
  logic [NWR-1:0] wr_en = '0;
  logic [NWR-1:0][1:0] wr_cls = '0;
  logic [NWR-1:0][6:0] wr_idx = '0;
  logic [NRD-1:0][6:0] rd_phys;
  logic [NRD-1:0] rd_hard;
  logic [NRD-1:0] rd_hard_val;
  logic [NWR-1:0][6:0] wr_phys;
  logic [NWR-1:0] wr_go;

  int vectors = 0;
  int bad = 0;
  int mgr = 0, mfr = 0, mpr = 0;

  always #5 clk = ~clk;

  rot_rename_unit #(.RD_PORTS(NRD), .WR_PORTS(NWR)) uut (
    .clk(clk), .rst_n(rst_n), .rotate(rotate), .base_clr(base_clr), .gr_grp(gr_grp),
    .rd_cls(rd_cls), .rd_idx(rd_idx), .wr_en(wr_en), .wr_cls(wr_cls), .wr_idx(wr_idx),
    .rd_phys(rd_phys), .rd_hard(rd_hard), .rd_hard_val(rd_hard_val),
    .wr_phys(wr_phys), .wr_go(wr_go)
  );

  function automatic int espan(int g);
    return ((g > 12) ? 12 : g) * 8;
  endfunction

  function automatic int emap(int c, int idx);
    int v;
    int s;
    if (c == 2) begin
      v = idx % 64;
      return (v >= 16) ? 16 + (v - 16 + mpr) % 48 : v;
    end
    if (c == 1) return (idx >= 32) ? 32 + (idx - 32 + mfr) % 96 : idx;
    s = espan(int'(gr_grp));
    if (s > 0 && idx >= 32 && idx < 32 + s) return 32 + (idx - 32 + mgr) % s;
    return idx;
  endfunction

  function automatic bit ehard(int c, int idx);
    if (c == 2) return (idx % 64) == 0;
    if (c == 1) return idx < 2;
    return idx == 0;
  endfunction

  function automatic bit eval1(int c, int idx);
    if (c == 2) return 1'b1;
    if (c == 1) return idx == 1;
    return 1'b0;
  endfunction

  task automatic cmp(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_ports(string tag);
    for (int i = 0; i < NRD; i++) begin
      cmp({tag, " rd_phys"}, int'(rd_phys[i]), emap(int'(rd_cls[i]), int'(rd_idx[i])));
      cmp({tag, " rd_hard"}, int'(rd_hard[i]), int'(ehard(int'(rd_cls[i]), int'(rd_idx[i]))));
      if (rd_hard[i])
        cmp({tag, " rd_hard_val"}, int'(rd_hard_val[i]), int'(eval1(int'(rd_cls[i]), int'(rd_idx[i]))));
    end
    for (int j = 0; j < NWR; j++) begin
      cmp({tag, " wr_phys"}, int'(wr_phys[j]), emap(int'(wr_cls[j]), int'(wr_idx[j])));
      cmp({tag, " R7 wr_go"}, int'(wr_go[j]),
          int'(wr_en[j] && !ehard(int'(wr_cls[j]), int'(wr_idx[j]))));
    end
  endtask

  // check at the settled combinational point, then clock and update the model
  task automatic cycle(string tag);
    int s;
    #1;
    check_ports(tag);
    @(posedge clk);
    if (base_clr) begin
      mgr = 0; mfr = 0; mpr = 0;
    end else if (rotate) begin
      mfr = (mfr + 95) % 96;
      mpr = (mpr + 47) % 48;
      s = espan(int'(gr_grp));
      mgr = (s == 0) ? 0 : ((mgr % s) + s - 1) % s;
    end
    @(negedge clk);
  endtask

  task automatic rand_ports();
    for (int i = 0; i < NRD; i++) begin
      rd_cls[i] = 2'($urandom_range(0, 3));
      rd_idx[i] = 7'($urandom_range(0, 127));
    end
    for (int j = 0; j < NWR; j++) begin
      wr_en[j]  = 1'($urandom_range(0, 1));
      wr_cls[j] = 2'($urandom_range(0, 3));
      wr_idx[j] = 7'($urandom_range(0, 127));
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    int p;
    int q;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state, identity with full windows
    gr_grp = 4'd12;
    for (int k = 0; k < 8; k++) begin
      rand_ports();
      cycle("R9 reset identity");
    end

    // R1: low region passthrough with bases moved
    rotate = 1'b1;
    repeat (5) cycle("R1 setup");
    rotate = 1'b0;
    for (int k = 0; k < 32; k++) begin
      rd_cls[0] = 2'd0; rd_idx[0] = 7'(k);
      rd_cls[1] = 2'd1; rd_idx[1] = 7'(k);
      rd_cls[2] = 2'd3; rd_idx[2] = 7'(k);
      cycle("R1 low pass");
    end

    // R3: value at r32 moves to r33; p16 moves to p17
    gr_grp = 4'd4;
    rd_cls[0] = 2'd0; rd_idx[0] = 7'd32;
    rd_cls[1] = 2'd2; rd_idx[1] = 7'd16;
    #1; p = int'(rd_phys[0]); q = int'(rd_phys[1]);
    rotate = 1'b1;
    cycle("R3 rotate step");
    rotate = 1'b0;
    rd_idx[0] = 7'd33; rd_idx[1] = 7'd17;
    #1;
    cmp("R3 r32 to r33", int'(rd_phys[0]), p);
    cmp("R3 p16 to p17", int'(rd_phys[1]), q);
    cycle("R3 after");

    // R4: clear beats rotate
    rotate = 1'b1; base_clr = 1'b1;
    cycle("R4 clr+rot");
    rotate = 1'b0; base_clr = 1'b0;
    rd_cls[0] = 2'd1; rd_idx[0] = 7'd100;
    rd_cls[1] = 2'd2; rd_idx[1] = 7'd40;
    rd_cls[2] = 2'd0; rd_idx[2] = 7'd50;
    #1;
    cmp("R4 fr zero base", int'(rd_phys[0]), 100);
    cmp("R4 pr zero base", int'(rd_phys[1]), 40);
    cmp("R4 gr zero base", int'(rd_phys[2]), 50);
    cycle("R4 after");

    // R5: size zero, size clamp
    gr_grp = 4'd0;
    rotate = 1'b1;
    for (int k = 0; k < 6; k++) begin
      rd_cls[0] = 2'd0; rd_idx[0] = 7'(32 + k * 15);
      cycle("R5 size zero");
    end
    gr_grp = 4'd15;
    repeat (3) cycle("R5 clamp rot");
    rotate = 1'b0;
    rd_cls[0] = 2'd0; rd_idx[0] = 7'd127;
    rd_cls[1] = 2'd0; rd_idx[1] = 7'd126;
    cycle("R5 clamp map");

    // R6 and R7: hardwired registers
    for (int k = 0; k < 4; k++) begin
      rd_cls[0] = 2'((k == 3) ? 2 : (k == 0 ? 0 : 1));
      rd_idx[0] = 7'((k == 2) ? 1 : 0);
      wr_en = '1;
      wr_cls[0] = rd_cls[0]; wr_idx[0] = rd_idx[0];
      wr_cls[1] = 2'd1;      wr_idx[1] = 7'd2;
      cycle("R6 R7 hardwired");
    end

    // R8: predicate bit 6 ignored
    rotate = 1'b1;
    for (int k = 0; k < 6; k++) begin
      rd_cls[0] = 2'd2; rd_idx[0] = 7'(64 + 10 * k);
      rd_cls[1] = 2'd2; rd_idx[1] = 7'(10 * k);
      cycle("R8 pred bit6");
    end
    rotate = 1'b0;

    // R2: random traffic with strobes and size changes
    for (int k = 0; k < 600; k++) begin
      rand_ports();
      rotate   = ($urandom_range(0, 2) == 0);
      base_clr = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 19) == 0) gr_grp = 4'($urandom_range(0, 15));
      cycle("R2 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

endmodule